// File: doc/BRIEF.md
# Dual-Slot Bus Frequency Arbiter

The arbiter sits between two processor sockets and the shared front-side bus clock setup. Each socket reports a 3-bit speed select code and an active-low presence flag. The block works out one common speed code for the bus. When both sockets hold a processor, the slower of the two wins. When only one socket holds a processor, that socket's code is used. Two status flags go with the common code. The first reports that both speeds match. The second reports that slot A is not the slower slot, and it also steers the output multiplexer.

The speed codes do not grow with frequency. The block therefore maps each code to a frequency rank and compares the ranks, never the raw bits. After reset the common code is held at a safe default until a reference-ready signal arrives. That signal comes from an asynchronous source and passes through a synchronizer. Once it has been seen, the block keeps tracking its inputs until the next reset. An occupied slot that presents the reserved code raises a sticky error flag.

Top module: `bus_speed_arbiter`

## Requirements
- R1: Code to speed (bits [2:0]): 101=100 MHz, 001=133, 011=166, 010=200, 000=266, 100=333, 110=400, and 111 is reserved. With both slots occupied, `common_code` carries the code of the lower frequency.
- R2: With only slot A present (`slot_a_present_n`=0, `slot_b_present_n`=1), `a_not_slower`=0, `speed_match`=0 and `common_code` is slot A's code. With only slot B present, `a_not_slower`=1, `speed_match`=0 and `common_code` is slot B's code.
- R3: With neither slot present, `a_not_slower`=1, `speed_match`=1 and `common_code` is slot B's code.
- R4: With both slots present, `a_not_slower`=1 exactly when A's frequency is strictly higher than B's, and `speed_match`=1 exactly when the two frequencies are equal. When the frequencies are equal, slot A's code is output.
- R5: While `rst_n` is low, `common_code`=101, and `speed_match`, `a_not_slower` and `reserved_err` are all 0.
- R6: After reset, `common_code` stays 101 until the fourth rising edge after `ref_ready` is first sampled high. From that edge on, it carries the computed code. The flags are never masked.
- R7: Once unmasked, the output keeps tracking the inputs even if `ref_ready` falls again. Only a reset masks it again.
- R8: A reserved code (111) ranks above every valid speed. An occupied slot with that code is therefore never chosen over a valid code in the other slot.
- R9: `reserved_err` goes high one edge after an occupied slot shows 111 and stays high until reset. A 111 code on an empty slot does not set it.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ready | input | 1 | Asynchronous reference-ready indication |
| slot_a_code | input | 3 | Speed select code of slot A |
| slot_a_present_n | input | 1 | Slot A occupied, active low |
| slot_b_code | input | 3 | Speed select code of slot B |
| slot_b_present_n | input | 1 | Slot B occupied, active low |
| common_code | output | 3 | Common bus speed code |
| speed_match | output | 1 | Both speeds equal |
| a_not_slower | output | 1 | Slot A not the slower slot; multiplexer select |
| reserved_err | output | 1 | Sticky reserved-code error |

## Verification
The hardest case to reach is the window between reset release and unmasking. During that window the flags must already follow the inputs while the common code stays at its default. The stimulus holds `ref_ready` low after reset and applies several occupancy patterns in that window. It then raises `ref_ready` on a fixed input and checks the third and fourth edges afterwards. The reserved code is kept out of the first random phase, so the error flag can be confirmed to stay low. A later phase admits it, and a second reset confirms the flag clears.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int CODE_W = 3;
  localparam int RANK_W = 3;
  localparam int SLOTS  = 2;

  typedef logic [CODE_W-1:0] speed_code_t;
  typedef logic [RANK_W-1:0] speed_rank_t;

  localparam speed_code_t CODE_RSVD    = 3'b111;
  localparam speed_code_t CODE_DEFAULT = 3'b101;
  localparam speed_rank_t RANK_RSVD    = 3'd7;

  // Non-monotonic code set mapped to ascending frequency rank.
  function automatic speed_rank_t code_to_rank(input speed_code_t c);
    speed_rank_t r;
    unique case (c)
      3'b101:  r = 3'd0;
      3'b001:  r = 3'd1;
      3'b011:  r = 3'd2;
      3'b010:  r = 3'd3;
      3'b000:  r = 3'd4;
      3'b100:  r = 3'd5;
      3'b110:  r = 3'd6;
      default: r = RANK_RSVD;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bsa_rank_decode.sv
module bsa_rank_decode
  import bsa_pkg::*;
(
  input  speed_code_t code_i,
  input  logic        present_n_i,
  output speed_rank_t rank_o,
  output logic        rsvd_hit_o
);
  always_comb begin
    rank_o     = code_to_rank(code_i);
    rsvd_hit_o = !present_n_i && (code_i == CODE_RSVD);
  end
endmodule

// File: rtl/bsa_slot_compare.sv
module bsa_slot_compare
  import bsa_pkg::*;
(
  input  speed_rank_t rank_a_i,
  input  speed_rank_t rank_b_i,
  input  logic        a_present_n_i,
  input  logic        b_present_n_i,
  output logic        pick_b_o,
  output logic        same_o
);
  logic a_in, b_in;

  always_comb begin
    a_in = !a_present_n_i;
    b_in = !b_present_n_i;
    unique case ({a_in, b_in})
      2'b11: begin
        pick_b_o = rank_a_i > rank_b_i;
        same_o   = rank_a_i == rank_b_i;
      end
      2'b10: begin
        pick_b_o = 1'b0;
        same_o   = 1'b0;
      end
      2'b01: begin
        pick_b_o = 1'b1;
        same_o   = 1'b0;
      end
      default: begin
        pick_b_o = 1'b1;
        same_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bsa_ready_sync.sv
module bsa_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_async_i,
  output logic ready_sync_o,
  output logic unmask_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              unmask_q;
  logic              unmask_d;

  always_comb begin
    sync_d[0] = ready_async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb sync_d[s] = sync_q[s-1];
  end

  always_comb begin
    unmask_d = unmask_q || sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      unmask_q <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      unmask_q <= unmask_d;
    end
  end

  assign ready_sync_o = sync_q[STAGES-1];
  assign unmask_o     = unmask_q;
endmodule

// File: rtl/bus_speed_arbiter.sv
module bus_speed_arbiter
  import bsa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_ready,
  input  logic [CODE_W-1:0] slot_a_code,
  input  logic              slot_a_present_n,
  input  logic [CODE_W-1:0] slot_b_code,
  input  logic              slot_b_present_n,
  output logic [CODE_W-1:0] common_code,
  output logic              speed_match,
  output logic              a_not_slower,
  output logic              reserved_err
);
  speed_code_t code_in   [SLOTS];
  logic        pres_n_in [SLOTS];
  speed_rank_t rank      [SLOTS];
  logic        rsvd_hit  [SLOTS];

  assign code_in[0]   = slot_a_code;
  assign code_in[1]   = slot_b_code;
  assign pres_n_in[0] = slot_a_present_n;
  assign pres_n_in[1] = slot_b_present_n;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    bsa_rank_decode u_dec (
      .code_i      (code_in[i]),
      .present_n_i (pres_n_in[i]),
      .rank_o      (rank[i]),
      .rsvd_hit_o  (rsvd_hit[i])
    );
  end

  logic pick_b, same;
  bsa_slot_compare u_cmp (
    .rank_a_i      (rank[0]),
    .rank_b_i      (rank[1]),
    .a_present_n_i (slot_a_present_n),
    .b_present_n_i (slot_b_present_n),
    .pick_b_o      (pick_b),
    .same_o        (same)
  );

  logic ready_sync, unmask_q;
  bsa_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready_async_i (ref_ready),
    .ready_sync_o  (ready_sync),
    .unmask_o      (unmask_q)
  );

  speed_code_t sel_code, code_d, code_q;
  logic        match_d, match_q, ageb_d, ageb_q, err_d, err_q;

  always_comb begin
    sel_code = pick_b ? slot_b_code : slot_a_code;
    code_d   = unmask_q ? sel_code : CODE_DEFAULT;
    match_d  = same;
    ageb_d   = pick_b;
    err_d    = err_q || rsvd_hit[0] || rsvd_hit[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_DEFAULT;
      match_q <= 1'b0;
      ageb_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      match_q <= match_d;
      ageb_q  <= ageb_d;
      err_q   <= err_d;
    end
  end

  assign common_code  = code_q;
  assign speed_match  = match_q;
  assign a_not_slower = ageb_q;
  assign reserved_err = err_q;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker
  import bsa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slot_a_present_n,
  input logic              slot_b_present_n,
  input logic [CODE_W-1:0] common_code,
  input logic              speed_match,
  input logic              a_not_slower,
  input logic              reserved_err,
  input logic              unmask_q,
  input logic              ready_sync
);
  // R6: masked output holds the default
  p_masked_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask_q |=> common_code == CODE_DEFAULT);
  // R7: unmask never drops without reset
  p_unmask_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_q |=> unmask_q);
  // R6: unmask only follows a synchronized ready
  p_unmask_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask_q ##1 unmask_q |-> $past(ready_sync));
  // R9: error flag sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err |=> reserved_err);
  // R2: only slot A
  p_only_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_a_present_n && slot_b_present_n) |=> (!a_not_slower && !speed_match));
  // R2: only slot B
  p_only_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_a_present_n && !slot_b_present_n) |=> (a_not_slower && !speed_match));
  // R3: no slot
  p_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_a_present_n && slot_b_present_n) |=> (a_not_slower && speed_match));
  // R4: strictly faster and equal exclude each other
  p_both_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_a_present_n && !slot_b_present_n) |=> !(a_not_slower && speed_match));
endmodule

bind bus_speed_arbiter bsa_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .slot_a_present_n (slot_a_present_n),
  .slot_b_present_n (slot_b_present_n),
  .common_code      (common_code),
  .speed_match      (speed_match),
  .a_not_slower     (a_not_slower),
  .reserved_err     (reserved_err),
  .unmask_q         (unmask_q),
  .ready_sync       (ready_sync)
);

// File: tb/bus_speed_arbiter_tb.sv
module bus_speed_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_ready = 1'b0;
  logic [2:0] a_code = 3'b101, b_code = 3'b101;
  logic       a_pn = 1'b1, b_pn = 1'b1;
  logic [2:0] common_code;
  logic       speed_match, a_not_slower, reserved_err;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit exp_err = 0;
  bit masked = 1;

  always #5 clk = ~clk;

  bus_speed_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .ref_ready(ref_ready),
    .slot_a_code(a_code), .slot_a_present_n(a_pn),
    .slot_b_code(b_code), .slot_b_present_n(b_pn),
    .common_code(common_code), .speed_match(speed_match),
    .a_not_slower(a_not_slower), .reserved_err(reserved_err)
  );

  function automatic int rank_of(logic [2:0] c);
    case (c)
      3'b101: return 0; 3'b001: return 1; 3'b011: return 2; 3'b010: return 3;
      3'b000: return 4; 3'b100: return 5; 3'b110: return 6;
      default: return 7;
    endcase
  endfunction

  // Expected {common, match, ageb} from the requirements
  function automatic logic [4:0] expect_of(logic [2:0] a, logic pa_n,
                                           logic [2:0] b, logic pb_n);
    logic ag, eq;
    if (!pa_n && !pb_n) begin
      ag = rank_of(a) > rank_of(b);
      eq = rank_of(a) == rank_of(b);
    end else if (!pa_n) begin
      ag = 0; eq = 0;
    end else if (!pb_n) begin
      ag = 1; eq = 0;
    end else begin
      ag = 1; eq = 1;
    end
    return {ag ? b : a, eq, ag};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge, check at the following negedge
  task automatic apply(string req, logic [2:0] a, logic pa_n,
                       logic [2:0] b, logic pb_n);
    logic [4:0] e;
    a_code = a; a_pn = pa_n; b_code = b; b_pn = pb_n;
    e = expect_of(a, pa_n, b, pb_n);
    if ((!pa_n && a == 3'b111) || (!pb_n && b == 3'b111)) exp_err = 1;
    @(negedge clk);
    chk({req, " common"}, common_code, masked ? 3'b101 : e[4:2]);
    chk({req, " match"}, speed_match, e[1]);
    chk({req, " ageb"}, a_not_slower, e[0]);
    chk({req, " err R9"}, reserved_err, exp_err);
  endtask

  task automatic do_reset();
    rst_n = 0; ref_ready = 0; masked = 1; exp_err = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 common", common_code, 3'b101);
    chk("R5 match", speed_match, 0);
    chk("R5 ageb", a_not_slower, 0);
    chk("R5 err", reserved_err, 0);
    rst_n = 1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] ra, rb;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // R6: flags live while the common code is still masked
    apply("R6 masked both", 3'b110, 0, 3'b001, 0);
    apply("R6 masked onlyA", 3'b000, 0, 3'b010, 1);
    apply("R6 masked none", 3'b000, 1, 3'b010, 1);
    // R6: unmask timing on a fixed input
    a_code = 3'b100; a_pn = 0; b_code = 3'b011; b_pn = 0;
    ref_ready = 1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R6 still default", common_code, 3'b101);
    end
    @(negedge clk);
    chk("R6 unmasked on 4th edge", common_code, 3'b011);
    masked = 0;
    // R7: ready drop has no effect
    ref_ready = 0;
    apply("R7 after ready drop", 3'b010, 0, 3'b110, 0);
    apply("R7 tracking", 3'b110, 0, 3'b000, 0);
    // R1/R4 equal and ordering directed
    apply("R4 equal", 3'b011, 0, 3'b011, 0);
    apply("R1 100 vs 400", 3'b110, 0, 3'b101, 0);
    apply("R1 333 vs 266", 3'b000, 0, 3'b100, 0);
    // R2/R3 directed
    apply("R2 onlyA", 3'b110, 0, 3'b101, 1);
    apply("R2 onlyB", 3'b101, 1, 3'b110, 0);
    apply("R3 none", 3'b001, 1, 3'b100, 1);
    // R9: reserved on empty slot ignored
    apply("R9 empty rsvd", 3'b111, 1, 3'b010, 0);
    // R10/R1: random without reserved
    for (int i = 0; i < 300; i++) begin
      ra = 3'($urandom_range(0, 6)); rb = 3'($urandom_range(0, 6));
      if (ra == 3'b111) ra = 3'b101;
      apply("R10 random", ra, 1'($urandom_range(0, 1) & $urandom_range(0, 1) ? 1 : 0),
            rb, 1'($urandom_range(0, 3) == 0));
    end
    // R8: reserved never chosen over a valid code
    apply("R8 rsvd A", 3'b111, 0, 3'b110, 0);
    apply("R8 rsvd B", 3'b001, 0, 3'b111, 0);
    // R10: random including reserved
    for (int i = 0; i < 300; i++) begin
      ra = 3'($urandom); rb = 3'($urandom);
      apply("R10 random rsvd", ra, 1'($urandom), rb, 1'($urandom));
    end
    // R9/R5: reset clears error and re-masks
    do_reset();
    apply("R9 cleared", 3'b000, 0, 3'b000, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule